// File: doc/BRIEF.md
# Counter Overflow Request Controller

This block turns overflow pulses from a group of event counters and one cycle counter into two system-level requests: an active-low reset request meant for a system reset controller, and an active-high debug request meant for the debug logic. Each request has its own enable mask. Every mask bit stands for one counter. A request is raised only when a counter overflows while its bit in that request's mask is set. Once raised, the request stays asserted until software removes the enable bit that caused it, or until the block is reset.

Each mask is reached through two register addresses. Writing ones to the "set" address turns mask bits on. Writing ones to the "clear" address turns them off. Zeros written to either address leave bits unchanged. Both addresses read back the current mask. The register port is a plain single-cycle strobe interface with no back-pressure: every access completes in the cycle it is presented. Read data and the access-error flag appear one cycle after the access. A privilege input and a user-access-enable input decide whether an access is honoured.

Top module: `ovf_req_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it, both masks are zero, `rst_req_n` is 1, `dbg_req` is 0, `reg_err` is 0 and `reg_rdata` is 0.
- R2: An honoured write to a set address (reset mask at `reg_addr`=0, debug mask at `reg_addr`=2) sets every implemented mask bit where `reg_wdata` is 1 and leaves the others unchanged.
- R3: An honoured write to a clear address (reset mask at 1, debug mask at 3) clears every implemented mask bit where `reg_wdata` is 1 and leaves the others unchanged.
- R4: Only mask bit 31 (cycle counter) and bits 2..0 (event counters 2..0) are implemented. Bits 30..3 always read 0, and writing them has no effect.
- R5: An honoured read of either the set or the clear address of a mask returns that mask on `reg_rdata` in the next cycle. When no honoured read takes place, `reg_rdata` is 0.
- R6: An overflow on a counter whose reset-mask bit is set drives `rst_req_n` low in the next cycle. It stays low until every such triggering bit has been cleared.
- R7: The debug mask works independently with the same layout and set/clear behaviour. An enabled overflow drives `dbg_req` high in the next cycle, and it stays high in the same sticky way.
- R8: An overflow on a counter whose mask bit is clear has no effect on the corresponding request.
- R9: An access is honoured whenever `priv_mode` is 1. When `priv_mode` is 0, it is honoured only if `user_acc_en` is 1.
- R10: A denied access leaves the masks unchanged, returns 0 on `reg_rdata`, and raises `reg_err` for exactly the next cycle. `reg_err` is 0 after an honoured access or idle cycle.
- R11: An overflow that arrives in the same cycle as a set write to its mask bit raises the request in the next cycle.
- R12: Clearing the last mask bit whose overflow is pending deasserts the request in the next cycle. A clear write in the same cycle as an overflow on that bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one access per cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 reset-set, 1 reset-clear, 2 debug-set, 3 debug-clear |
| reg_wdata | input | 32 | Write data, ones select mask bits |
| priv_mode | input | 1 | Accessor is privileged |
| user_acc_en | input | 1 | Unprivileged access permitted |
| evt_ovf | input | 3 | Overflow pulses of event counters 2..0 |
| cyc_ovf | input | 1 | Overflow pulse of the cycle counter |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| reg_err | output | 1 | Denied-access flag, one cycle |
| rst_req_n | output | 1 | Reset request, active low |
| dbg_req | output | 1 | Debug request, active high |

## Verification
Overflows are first applied with both masks empty, which shows that an unmasked overflow is not treated as a request. Overflows are then applied to single enabled bits, with masks set differently per request, which shows whether the two channels really stay separate. Stuck requests are held over idle cycles and then released by partial and full clears, which distinguishes per-bit pending from a single shared flag. Same-cycle set-plus-overflow and clear-plus-overflow cases check the ordering of the write and the capture. A long random phase mixes privileged and user accesses with overflow bursts, and its result is compared every cycle against a behavioural model.

// File: rtl/ovf_req_pkg.sv
package ovf_req_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned NUM_CH = 2;   // channel 0: reset request, channel 1: debug request

  typedef enum logic [1:0] {
    SEL_RST_SET = 2'd0,
    SEL_RST_CLR = 2'd1,
    SEL_DBG_SET = 2'd2,
    SEL_DBG_CLR = 2'd3
  } reg_sel_e;

  // Mask of implemented source bits: event counters from bit 0 up, cycle counter at cbit.
  function automatic logic [REG_W-1:0] src_mask(input int unsigned nevt, input int unsigned cbit);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nevt; i++) m[i] = 1'b1;
    m[cbit] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/ovf_access_gate.sv
module ovf_access_gate (
  input  logic reg_en,
  input  logic reg_wr,
  input  logic priv_mode,
  input  logic user_acc_en,
  output logic wr_ok,
  output logic rd_ok,
  output logic deny
);
  logic permit;

  always_comb begin
    permit = priv_mode | user_acc_en;
    wr_ok  = reg_en &  reg_wr & permit;
    rd_ok  = reg_en & ~reg_wr & permit;
    deny   = reg_en & ~permit;
  end
endmodule

// File: rtl/ovf_mask_reg.sv
module ovf_mask_reg #(
  parameter int unsigned           W    = 32,
  parameter logic [W-1:0]          IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_d
);
  logic [W-1:0] sel;

  always_comb begin
    sel    = wdata & IMPL;
    mask_d = mask_q;
    if (set_we) mask_d = mask_d | sel;
    if (clr_we) mask_d = mask_d & ~sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/ovf_req_sticky.sv
module ovf_req_sticky #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_vec,
  input  logic [W-1:0] mask_d,
  output logic         req_q
);
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;

  // A source stays pending while its enable holds; the enable seen is the post-write mask.
  always_comb pend_d = (pend_q | src_vec) & mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= |pend_d;
    end
  end
endmodule

// File: rtl/ovf_req_ctrl.sv
module ovf_req_ctrl
  import ovf_req_pkg::*;
#(
  parameter int unsigned NUM_EVT = 3,
  parameter int unsigned CYC_BIT = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_en,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic                priv_mode,
  input  logic                user_acc_en,
  input  logic [NUM_EVT-1:0]  evt_ovf,
  input  logic                cyc_ovf,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                reg_err,
  output logic                rst_req_n,
  output logic                dbg_req
);
  localparam logic [REG_W-1:0] IMPL_MASK = src_mask(NUM_EVT, CYC_BIT);

  logic             wr_ok;
  logic             rd_ok;
  logic             deny;
  logic [REG_W-1:0] src_vec;
  logic [REG_W-1:0] ch_mask_q [NUM_CH];
  logic [REG_W-1:0] ch_mask_d [NUM_CH];
  logic [NUM_CH-1:0] ch_req;
  logic [REG_W-1:0] rd_mux;
  reg_sel_e         sel;

  ovf_access_gate u_gate (
    .reg_en      (reg_en),
    .reg_wr      (reg_wr),
    .priv_mode   (priv_mode),
    .user_acc_en (user_acc_en),
    .wr_ok       (wr_ok),
    .rd_ok       (rd_ok),
    .deny        (deny)
  );

  always_comb begin
    src_vec                = '0;
    src_vec[NUM_EVT-1:0]   = evt_ovf;
    src_vec[CYC_BIT]       = cyc_ovf;
  end

  assign sel = reg_sel_e'(reg_addr);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic set_we;
    logic clr_we;
    reg_sel_e set_code;
    reg_sel_e clr_code;

    assign set_code = (c == 0) ? SEL_RST_SET : SEL_DBG_SET;
    assign clr_code = (c == 0) ? SEL_RST_CLR : SEL_DBG_CLR;
    assign set_we   = wr_ok && (sel == set_code);
    assign clr_we   = wr_ok && (sel == clr_code);

    ovf_mask_reg #(.W(REG_W), .IMPL(IMPL_MASK)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_we),
      .clr_we (clr_we),
      .wdata  (reg_wdata),
      .mask_q (ch_mask_q[c]),
      .mask_d (ch_mask_d[c])
    );

    ovf_req_sticky #(.W(REG_W)) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_vec (src_vec),
      .mask_d  (ch_mask_d[c]),
      .req_q   (ch_req[c])
    );
  end

  // reg_addr[1] picks the channel; both addresses of a channel read the same mask.
  always_comb rd_mux = reg_addr[1] ? ch_mask_q[1] : ch_mask_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      reg_rdata <= rd_ok ? rd_mux : '0;
      reg_err   <= deny;
    end
  end

  assign rst_req_n = ~ch_req[0];
  assign dbg_req   =  ch_req[1];
endmodule

// File: rtl/ovf_req_ctrl_chk.sv
module ovf_req_ctrl_chk #(
  parameter int unsigned NUM_EVT = 3,
  parameter int unsigned CYC_BIT = 31
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_en,
  input logic               reg_wr,
  input logic [1:0]         reg_addr,
  input logic [31:0]        reg_wdata,
  input logic               priv_mode,
  input logic               user_acc_en,
  input logic [NUM_EVT-1:0] evt_ovf,
  input logic               cyc_ovf,
  input logic [31:0]        reg_rdata,
  input logic               reg_err,
  input logic               rst_req_n,
  input logic               dbg_req
);
  logic allowed;
  assign allowed = priv_mode || user_acc_en;

  a_r10_deny_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !allowed) |=> reg_err);

  a_r10_deny_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_wr && !allowed) |=> (reg_rdata == '0));

  a_r9_ok_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_en && !allowed) |=> !reg_err);

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[CYC_BIT-1:NUM_EVT] == '0);

  a_r6_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req_n && !(reg_en && reg_wr && allowed && reg_addr == 2'd1)) |=> !rst_req_n);

  a_r7_dbg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !(reg_en && reg_wr && allowed && reg_addr == 2'd3)) |=> dbg_req);

  a_r11_set_with_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ovf && reg_en && reg_wr && allowed && reg_addr == 2'd0 && reg_wdata[CYC_BIT]) |=> !rst_req_n);

  a_r8_no_src_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_n && !cyc_ovf && evt_ovf == '0) |=> rst_req_n);
endmodule

bind ovf_req_ctrl ovf_req_ctrl_chk #(.NUM_EVT(NUM_EVT), .CYC_BIT(CYC_BIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_en      (reg_en),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .priv_mode   (priv_mode),
  .user_acc_en (user_acc_en),
  .evt_ovf     (evt_ovf),
  .cyc_ovf     (cyc_ovf),
  .reg_rdata   (reg_rdata),
  .reg_err     (reg_err),
  .rst_req_n   (rst_req_n),
  .dbg_req     (dbg_req)
);

// File: tb/ovf_req_ctrl_tb_top.sv
module ovf_req_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        priv_mode = 1'b1;
  logic        user_acc_en = 1'b0;
  logic [2:0]  evt_ovf = '0;
  logic        cyc_ovf = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        rst_req_n;
  logic        dbg_req;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string tag   = "R1";

  always #2 clk = ~clk;

  ovf_req_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .priv_mode(priv_mode), .user_acc_en(user_acc_en),
    .evt_ovf(evt_ovf), .cyc_ovf(cyc_ovf), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .rst_req_n(rst_req_n), .dbg_req(dbg_req)
  );

  // Behavioural reference: source k lives at mask bit k for events, bit 31 for cycles.
  localparam logic [31:0] IMPL = 32'h8000_0007;
  logic [31:0] m_mask [2];
  logic [31:0] m_pend [2];
  logic [31:0] m_rdata;
  bit          m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask[0] = '0; m_mask[1] = '0; m_pend[0] = '0; m_pend[1] = '0;
      m_rdata = '0; m_err = 1'b0;
    end else begin
      bit ok;
      int ch;
      logic [31:0] src;
      ok = priv_mode || user_acc_en;
      ch = reg_addr[1] ? 1 : 0;
      m_rdata = (reg_en && !reg_wr && ok) ? m_mask[ch] : 32'd0;
      m_err   = reg_en && !ok;
      if (reg_en && reg_wr && ok) begin
        if (reg_addr[0]) m_mask[ch] = m_mask[ch] & ~(reg_wdata & IMPL);
        else             m_mask[ch] = m_mask[ch] |  (reg_wdata & IMPL);
      end
      src = {cyc_ovf, 28'd0, evt_ovf};
      for (int k = 0; k < 2; k++) m_pend[k] = (m_pend[k] | src) & m_mask[k];
    end
  end

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk(tag, "rst_req_n", {31'd0, rst_req_n}, {31'd0, m_pend[0] == 0});
    chk(tag, "dbg_req",   {31'd0, dbg_req},   {31'd0, m_pend[1] != 0});
    chk(tag, "reg_err",   {31'd0, reg_err},   {31'd0, m_err});
    chk(tag, "reg_rdata", reg_rdata, m_rdata);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic acc(input logic wr, input logic [1:0] a, input logic [31:0] d);
    reg_en = 1'b1; reg_wr = wr; reg_addr = a; reg_wdata = d;
    tick();
    reg_en = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic c, input logic [2:0] e);
    cyc_ovf = c; evt_ovf = e;
    tick();
    cyc_ovf = 1'b0; evt_ovf = '0;
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    tag = "R1";
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1", "rst_req_n after reset", {31'd0, rst_req_n}, 32'd1);

    tag = "R5";
    for (int a = 0; a < 4; a++) acc(1'b0, 2'(a), '0);

    tag = "R8";
    pulse(1'b1, 3'b111); tick();
    chk("R8", "rst_req_n masked", {31'd0, rst_req_n}, 32'd1);

    tag = "R2 R4";
    acc(1'b1, 2'd0, 32'hFFFF_FFFF);
    acc(1'b0, 2'd0, '0);
    chk("R4", "reset mask readback", reg_rdata, 32'h8000_0007);
    tag = "R5";
    acc(1'b0, 2'd1, '0);
    chk("R5", "clear addr readback", reg_rdata, 32'h8000_0007);

    tag = "R3";
    acc(1'b1, 2'd1, 32'h0000_0006);
    acc(1'b0, 2'd0, '0);
    chk("R3", "after clear", reg_rdata, 32'h8000_0001);

    tag = "R8";
    pulse(1'b0, 3'b010); tick();
    chk("R8", "disabled evt1", {31'd0, rst_req_n}, 32'd1);

    tag = "R6";
    pulse(1'b0, 3'b001);
    chk("R6", "rst_req_n low", {31'd0, rst_req_n}, 32'd0);
    repeat (5) tick();
    chk("R6", "rst_req_n sticky", {31'd0, rst_req_n}, 32'd0);
    acc(1'b1, 2'd1, 32'h8000_0000);   // clearing a bit not pending keeps it low
    chk("R6", "unrelated clear", {31'd0, rst_req_n}, 32'd0);
    tag = "R12";
    acc(1'b1, 2'd1, 32'h0000_0001);
    chk("R12", "released", {31'd0, rst_req_n}, 32'd1);

    tag = "R7";
    acc(1'b1, 2'd2, 32'h0000_0004);
    pulse(1'b0, 3'b100);
    chk("R7", "dbg_req high", {31'd0, dbg_req}, 32'd1);
    chk("R7", "rst independent", {31'd0, rst_req_n}, 32'd1);
    repeat (3) tick();
    acc(1'b1, 2'd3, 32'h0000_0004);
    chk("R7", "dbg released", {31'd0, dbg_req}, 32'd0);

    tag = "R10";
    priv_mode = 1'b0; user_acc_en = 1'b0;
    acc(1'b1, 2'd0, 32'h8000_0007);
    chk("R10", "err pulse", {31'd0, reg_err}, 32'd1);
    tick();
    chk("R10", "err one cycle", {31'd0, reg_err}, 32'd0);
    acc(1'b0, 2'd0, '0);
    chk("R10", "denied read", reg_rdata, 32'd0);
    tag = "R9";
    user_acc_en = 1'b1;
    acc(1'b0, 2'd0, '0);
    chk("R9", "user read ok, mask unchanged", reg_rdata, 32'd0);
    acc(1'b1, 2'd2, 32'h0000_0002);
    priv_mode = 1'b1; user_acc_en = 1'b0;
    acc(1'b0, 2'd3, '0);
    chk("R9", "user write took", reg_rdata, 32'h0000_0002);

    tag = "R11";
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h8000_0000; cyc_ovf = 1'b1;
    tick();
    reg_en = 1'b0; reg_wr = 1'b0; cyc_ovf = 1'b0;
    chk("R11", "same-cycle set", {31'd0, rst_req_n}, 32'd0);
    tag = "R12";
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h8000_0000; cyc_ovf = 1'b1;
    tick();
    reg_en = 1'b0; reg_wr = 1'b0; cyc_ovf = 1'b0;
    chk("R12", "clear wins", {31'd0, rst_req_n}, 32'd1);

    tag = "R2 R3 R6 R7 R9 R10";
    for (int i = 0; i < 2000; i++) begin
      reg_en      = ($urandom % 3) == 0;
      reg_wr      = $urandom % 2;
      reg_addr    = 2'($urandom % 4);
      reg_wdata   = $urandom;
      priv_mode   = ($urandom % 4) != 0;
      user_acc_en = $urandom % 2;
      evt_ovf     = (($urandom % 4) == 0) ? 3'($urandom) : 3'd0;
      cyc_ovf     = ($urandom % 8) == 0;
      tick();
    end
    reg_en = 1'b0; evt_ovf = '0; cyc_ovf = 1'b0;

    tag = "R1";
    rst_n = 1'b0;
    tick();
    chk("R1", "dbg_req in reset", {31'd0, dbg_req}, 32'd0);
    rst_n = 1'b1;
    tick();

    done = 1'b1;
    report();
    $finish;
  end
endmodule